// File: doc/BRIEF.md
# PLL Clock Control Sequencer

This block is the register-controlled sequencer in front of a processor's PLL. It keeps the configuration the software writes: a 4-bit frequency multiplier, a 2-bit post-divider code and a disable bit for the missing-clock detector. It checks that writes arrive in a legal order, so that the clock tree never takes a step it should not. The analog PLL is not modelled. A relock is stood in for by a counter that runs on oscillator ticks.

When the multiplier changes, the sequencer drops its lock-done status. It then steers the core clock source to the oscillator divided by two until the lock counter expires. After that the new multiplier takes effect on the PLL path. A missing reference clock, unless the detector is disabled, latches a limp status. That status overrides every other source choice and blocks further multiplier changes.

Every configuration write needs the write-protect enable. A write that breaks an ordering rule leaves the register unchanged and sets a sticky error flag. The outputs carry a source select code together with the multiplier and divide values in effect, so downstream clock logic needs no further decoding.

Top module: `clkctl_seq`

## Requirements
- R1: After reset, the multiplier reads 0 and the post-divider code reads 0. Lock-done reads 1, and the detector-disable, limp and error bits read 0. The source select is 1 (PLL path), the effective multiplier is 0 and the effective divide is 4.
- R2: A write with `prot_en` low changes no register and no output.
- R3: A write of a different multiplier value is rejected while the post-divider code is nonzero. A rejected write leaves the multiplier unchanged and sets the error flag (status bit 5).
- R4: Post-divider code 0 gives an effective divide of 4. Codes 1 and 2 give 2, and code 3 gives 1.
- R5: A write of post-divider code 3 is accepted only when the current code is 2. Otherwise the code is unchanged and the error flag is set.
- R6: An accepted multiplier change clears lock-done (status bit 3) and sets the source select to 0 (oscillator/2). After `LOCK_TICKS` oscillator ticks, lock-done returns to 1, the source returns to 1 and the effective multiplier takes the new value.
- R7: A write of the multiplier value already held does not restart a running lock count.
- R8: `clk_missing` with the detector enabled sets the limp status (status bit 4). Limp forces source select 2 and stays set until reset.
- R9: While detector-disable (control bit 2) is set, `clk_missing` has no effect on the limp status.
- R10: A multiplier change written while limp is set is rejected and sets the error flag.
- R11: The error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| prot_en | input | 1 | Write-protect enable; writes are ignored while it is low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = multiplier register, 1 = control register |
| wr_data | input | DATA_W | Write data: multiplier in [3:0]; control has the divider code in [1:0] and detector-disable in [2] |
| rd_addr | input | 1 | Read select, same map as `wr_addr` |
| rd_data | output | DATA_W | Addr 0: multiplier [3:0]. Addr 1: code [1:0], detector-disable [2], lock-done [3], limp [4], error [5] |
| osc_tick | input | 1 | One pulse per oscillator period |
| clk_missing | input | 1 | Missing reference clock indication |
| src_sel | output | 2 | 0 = oscillator/2, 1 = PLL path, 2 = limp |
| eff_mult | output | MULT_W | Multiplier in effect |
| eff_div | output | 3 | Divide value in effect (4, 2 or 1) |

## Verification
The divider code is walked through every value from each legal and illegal predecessor. This separates the accepted step from 2 to 3 from the rejected jumps from 0 and 1, and shows that code 1 decodes the same as code 2. A multiplier change is tried once with the divider at zero and once with it nonzero, which shows the order check apart from the write itself. The lock window is counted exactly, one tick short and then on the final tick. A same-value rewrite is placed mid-count, where a restart would show up as a late lock. `clk_missing` is pulsed with the detector disabled and then enabled, which tells the disable gating apart from the sticky limp latch and its precedence over the other sources.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   typedef enum logic [1:0] {
      SRC_OSC_HALF = 2'd0,
      SRC_PLL      = 2'd1,
      SRC_LIMP     = 2'd2
   } clk_src_t;

   localparam logic [1:0] DIV_CODE_QUARTER = 2'd0;
   localparam logic [1:0] DIV_CODE_HALF    = 2'd2;
   localparam logic [1:0] DIV_CODE_FULL    = 2'd3;

   function automatic logic [2:0] div_value(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd4;
         2'd1,
         2'd2:    return 3'd2;
         default: return 3'd1;
      endcase
   endfunction
endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs #(
   parameter int MULT_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_en,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clk_missing,
   output logic [MULT_W-1:0] mult_o,
   output logic [1:0]        divsel_o,
   output logic              detoff_o,
   output logic              limp_o,
   output logic              err_o,
   output logic              start_o
);
   import clkctl_pkg::*;

   logic [MULT_W-1:0] mult_q;
   logic [1:0]        divsel_q;
   logic              detoff_q, limp_q, err_q;
   logic              wr_mult, wr_ctrl, mult_diff, mult_ok, div_ok;
   logic [1:0]        new_div;

   assign wr_mult   = wr_en && prot_en && !wr_addr;
   assign wr_ctrl   = wr_en && prot_en &&  wr_addr;
   assign mult_diff = wr_data[MULT_W-1:0] != mult_q;
   assign mult_ok   = (divsel_q == DIV_CODE_QUARTER) && !limp_q;
   assign new_div   = wr_data[1:0];
   assign div_ok    = (new_div != DIV_CODE_FULL) || (divsel_q == DIV_CODE_HALF);
   assign start_o   = wr_mult && mult_diff && mult_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mult_q   <= '0;
         divsel_q <= DIV_CODE_QUARTER;
         detoff_q <= 1'b0;
         limp_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         if (start_o)
            mult_q <= wr_data[MULT_W-1:0];
         if (wr_ctrl) begin
            detoff_q <= wr_data[2];
            if (div_ok)
               divsel_q <= new_div;
         end
         if ((wr_mult && mult_diff && !mult_ok) || (wr_ctrl && !div_ok))
            err_q <= 1'b1;
         if (clk_missing && !detoff_q)
            limp_q <= 1'b1;
      end
   end

   assign mult_o   = mult_q;
   assign divsel_o = divsel_q;
   assign detoff_o = detoff_q;
   assign limp_o   = limp_q;
   assign err_o    = err_q;

   assert_prot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !prot_en |=> $stable(mult_q) && $stable(divsel_q) && $stable(detoff_q));
   assert_mult_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (divsel_q != DIV_CODE_QUARTER) |=> $stable(mult_q));
   assert_full_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (divsel_q == DIV_CODE_FULL) && ($past(divsel_q) != DIV_CODE_FULL)
         |-> $past(divsel_q) == DIV_CODE_HALF);
   assert_limp_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      limp_q |=> limp_q);
   assert_detoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (detoff_q && !limp_q) |=> !limp_q);
   assert_limp_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      limp_q |=> $stable(mult_q));
   assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: rtl/clkctl_lock.sv
module clkctl_lock #(
   parameter int MULT_W     = 4,
   parameter int LOCK_TICKS = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              osc_tick,
   input  logic [MULT_W-1:0] mult_cfg,
   output logic              done_o,
   output logic [MULT_W-1:0] act_mult_o
);
   localparam int CNT_W = $clog2(LOCK_TICKS + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_TICKS);

   logic [CNT_W-1:0]  cnt_q;
   logic              done_q;
   logic [MULT_W-1:0] act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b1;
         act_q  <= '0;
      end else if (start) begin
         cnt_q  <= CNT_LOAD;
         done_q <= 1'b0;
      end else if (!done_q && osc_tick) begin
         if (cnt_q == CNT_W'(1)) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
            act_q  <= mult_cfg;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign done_o     = done_q;
   assign act_mult_o = act_q;

   assert_lock_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done_q);
   assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !start) |=> done_q);
   assert_act_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |=> $stable(act_q) || done_q);
endmodule

// File: rtl/clkctl_outsel.sv
module clkctl_outsel #(
   parameter int MULT_W  = 4,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              limp,
   input  logic              lock_done,
   input  logic [1:0]        divsel,
   input  logic [MULT_W-1:0] act_mult,
   output logic [1:0]        src_sel_o,
   output logic [MULT_W-1:0] eff_mult_o,
   output logic [2:0]        eff_div_o
);
   import clkctl_pkg::*;

   clk_src_t src_c;

   always_comb begin
      if (limp)            src_c = SRC_LIMP;
      else if (!lock_done) src_c = SRC_OSC_HALF;
      else                 src_c = SRC_PLL;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               src_sel_o  <= SRC_PLL;
               eff_mult_o <= '0;
               eff_div_o  <= 3'd4;
            end else begin
               src_sel_o  <= src_c;
               eff_mult_o <= act_mult;
               eff_div_o  <= div_value(divsel);
            end
         end
      end else begin : g_comb
         assign src_sel_o  = src_c;
         assign eff_mult_o = act_mult;
         assign eff_div_o  = div_value(divsel);
      end
   endgenerate

   assert_src_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      src_sel_o != 2'd3);
   assert_div_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(eff_div_o));
endmodule

// File: rtl/clkctl_seq.sv
module clkctl_seq #(
   parameter int LOCK_TICKS = 1024,
   parameter int MULT_W     = 4,
   parameter int DATA_W     = 8,
   parameter bit REG_OUT    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_en,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              osc_tick,
   input  logic              clk_missing,
   output logic [1:0]        src_sel,
   output logic [MULT_W-1:0] eff_mult,
   output logic [2:0]        eff_div
);
   generate
      if (MULT_W != 4)     begin : g_bad_mult $error("MULT_W must be 4"); end
      if (DATA_W < 6)      begin : g_bad_data $error("DATA_W must be at least 6"); end
      if (LOCK_TICKS < 2)  begin : g_bad_lock $error("LOCK_TICKS must be at least 2"); end
   endgenerate

   logic [MULT_W-1:0] mult_cfg, act_mult;
   logic [1:0]        divsel;
   logic              detoff, limp, err, start, lock_done;

   clkctl_regs #(.MULT_W(MULT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .clk_missing(clk_missing),
      .mult_o(mult_cfg), .divsel_o(divsel), .detoff_o(detoff),
      .limp_o(limp), .err_o(err), .start_o(start));

   clkctl_lock #(.MULT_W(MULT_W), .LOCK_TICKS(LOCK_TICKS)) u_lock (
      .clk(clk), .rst_n(rst_n), .start(start), .osc_tick(osc_tick),
      .mult_cfg(mult_cfg), .done_o(lock_done), .act_mult_o(act_mult));

   clkctl_outsel #(.MULT_W(MULT_W), .REG_OUT(REG_OUT)) u_out (
      .clk(clk), .rst_n(rst_n), .limp(limp), .lock_done(lock_done),
      .divsel(divsel), .act_mult(act_mult), .src_sel_o(src_sel),
      .eff_mult_o(eff_mult), .eff_div_o(eff_div));

   always_comb begin
      rd_data = '0;
      if (!rd_addr) begin
         rd_data[MULT_W-1:0] = mult_cfg;
      end else begin
         rd_data[1:0] = divsel;
         rd_data[2]   = detoff;
         rd_data[3]   = lock_done;
         rd_data[4]   = limp;
         rd_data[5]   = err;
      end
   end
endmodule

// File: tb/clkctl_seq_tb_top.sv
module clkctl_seq_tb_top;
   localparam int LT = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prot_en = 1'b0, wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       osc_tick = 1'b0, clk_missing = 1'b0;
   logic [7:0] rd_data;
   logic [1:0] src_sel;
   logic [3:0] eff_mult;
   logic [2:0] eff_div;
   int         n_run = 0, n_fail = 0;

   always #4 clk = ~clk;

   clkctl_seq #(.LOCK_TICKS(LT)) dut_i (
      .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .osc_tick(osc_tick), .clk_missing(clk_missing), .src_sel(src_sel),
      .eff_mult(eff_mult), .eff_div(eff_div));

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int rd_mult();
      return int'(dut_i.rd_data[3:0]);
   endfunction

   task automatic rd(input logic a, output logic [7:0] v);
      rd_addr = a; #1; v = rd_data;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic [7:0] d, input logic p);
      @(negedge clk);
      prot_en = p; wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; prot_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         osc_tick = 1'b1; @(negedge clk);
      end
      osc_tick = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      do_reset();
      rd(1'b0, v); chk("R1 mult", v[3:0], 0);
      rd(1'b1, v); chk("R1 ctrl", v[5:0], 6'b001000);
      chk("R1 src", src_sel, 1); chk("R1 div", eff_div, 4); chk("R1 emult", eff_mult, 0);
   endtask

   task automatic t_protect();
      logic [7:0] v;
      do_reset();
      wr(1'b0, 8'd5, 1'b0);
      rd(1'b0, v); chk("R2 mult", v[3:0], 0); chk("R2 src", src_sel, 1);
      wr(1'b1, 8'h06, 1'b0);
      rd(1'b1, v); chk("R2 ctrl", v[5:0], 6'b001000); chk("R2 div", eff_div, 4);
   endtask

   task automatic t_divsel();
      logic [7:0] v;
      do_reset();
      wr(1'b1, 8'd3, 1'b1);
      rd(1'b1, v); chk("R5 from0", v[1:0], 0); chk("R5 err", v[5], 1);
      wr(1'b1, 8'd1, 1'b1); chk("R4 code1", eff_div, 2);
      wr(1'b1, 8'd3, 1'b1);
      rd(1'b1, v); chk("R5 from1", v[1:0], 1); chk("R4 stay", eff_div, 2);
      wr(1'b1, 8'd2, 1'b1); chk("R4 code2", eff_div, 2);
      wr(1'b1, 8'd3, 1'b1);
      rd(1'b1, v); chk("R5 from2", v[1:0], 3); chk("R4 code3", eff_div, 1);
      wr(1'b1, 8'd0, 1'b1); chk("R4 code0", eff_div, 4);
      rd(1'b1, v); chk("R11 err held", v[5], 1);
   endtask

   task automatic t_mult_order();
      logic [7:0] v;
      do_reset();
      wr(1'b1, 8'd2, 1'b1);
      wr(1'b0, 8'd5, 1'b1);
      rd(1'b0, v); chk("R3 mult kept", v[3:0], 0);
      rd(1'b1, v); chk("R3 err", v[5], 1); chk("R3 lock", v[3], 1);
      chk("R3 src", src_sel, 1);
   endtask

   task automatic t_lock();
      logic [7:0] v;
      do_reset();
      wr(1'b0, 8'd5, 1'b1);
      rd(1'b0, v); chk("R6 mult", v[3:0], 5);
      rd(1'b1, v); chk("R6 lock clr", v[3], 0); chk("R6 err", v[5], 0);
      chk("R6 src osc", src_sel, 0); chk("R6 old mult", eff_mult, 0);
      ticks(500);
      wr(1'b0, 8'd5, 1'b1);
      ticks(LT - 501);
      rd(1'b1, v); chk("R7 not yet", v[3], 0); chk("R6 src still", src_sel, 0);
      ticks(1);
      rd(1'b1, v); chk("R7 lock on time", v[3], 1);
      chk("R6 src pll", src_sel, 1); chk("R6 new mult", eff_mult, 5);
   endtask

   task automatic t_limp();
      logic [7:0] v;
      do_reset();
      wr(1'b1, 8'h04, 1'b1);
      @(negedge clk); clk_missing = 1'b1; @(negedge clk); clk_missing = 1'b0;
      rd(1'b1, v); chk("R9 no limp", v[4], 0); chk("R9 src", src_sel, 1);
      wr(1'b1, 8'h00, 1'b1);
      @(negedge clk); clk_missing = 1'b1; @(negedge clk); clk_missing = 1'b0;
      @(negedge clk);
      rd(1'b1, v); chk("R8 limp", v[4], 1); chk("R8 src", src_sel, 2);
      wr(1'b0, 8'd7, 1'b1);
      rd(1'b0, v); chk("R10 mult kept", v[3:0], 0);
      rd(1'b1, v); chk("R10 err", v[5], 1); chk("R8 sticky", v[4], 1);
      do_reset();
      rd(1'b1, v); chk("R8 reset clears", v[4], 0); chk("R11 reset clears", v[5], 0);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_protect();
            t_divsel();
            t_mult_order();
            t_lock();
            t_limp();
         end
         begin
            repeat (20000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule